// File: doc/BRIEF.md
# Bank Activation Timing Tracker

This block watches the command pins of a DDR2 SDRAM interface and checks that the row-level timing rules hold. On every rising clock edge it decodes chip-select, row strobe, column strobe and write enable into an activate, precharge, read, write or idle command. It tracks which of four banks are open and which row each open bank holds. It reports any command that arrives too early, or that names a bank in the wrong state.

Reads and writes can be posted. A column command may be placed on the bus before the activate-to-column delay has elapsed, as long as the programmed additive latency pushes its internal issue far enough back. The tracker holds each posted column command in a short delay line and runs its checks at the internal issue time, not at the bus time. Timing limits are applied through configuration inputs, in clock cycles. A violation appears as a one-cycle pulse together with a 3-bit reason code.

Top module: `act_timing_guard`

## Requirements
- R1: An activate (chip-select low, row strobe low, column strobe high, write enable high) to a closed bank opens that bank and records the row address as its open row.
- R2: A precharge (chip-select low, row strobe low, column strobe high, write enable low) closes an open bank. A precharge to a closed bank changes nothing and raises no violation.
- R3: An activate to a bank that is already open raises code 1 and is ignored: the bank's open row is unchanged.
- R4: An activate that comes fewer than `cfg_trc` cycles after the previous activate of the same bank raises code 2. The activate still takes effect.
- R5: An activate that comes fewer than `cfg_trp` cycles after the precharge of that bank raises code 3. The activate still takes effect.
- R6: An activate that comes fewer than `cfg_trrd` cycles after an activate to a different bank raises code 4. The activate still takes effect.
- R7: A precharge that comes fewer than `cfg_tras` cycles after the activate of that bank raises code 5. The bank still closes.
- R8: A read (column strobe low, write enable high) or a write (column strobe low, write enable low) presented in cycle c is issued internally in cycle c + `cfg_al`. If that issue comes fewer than `cfg_trcd` cycles after the bank's activate, code 6 is raised.
- R9: A read or write whose internal issue finds its bank closed raises code 7.
- R10: A violation found in cycle n shows as `viol`=1 with its code on `viol_code` in cycle n+1 only. Otherwise `viol` is 0 and the code is 0. A posted issue violation wins over a bus command violation in the same cycle. Among activate faults, code 1 wins over 2, 2 over 3, and 3 over 4.
- R11: Deselect (chip-select high) and any other pin pattern, such as refresh (low, low, low, high), change no bank state and raise no violation.
- R12: After synchronous reset all banks are closed, no violation is shown, and all counters are clear, so an activate right after reset is legal.
- R13: With tRCD=3, AL=2, tRP=3 and tRRD=2, a read posted one cycle after an activate raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | BANK_W | Bank address of the command |
| row_addr | input | ROW_W | Row address used by activate |
| cfg_trcd | input | CNT_W | Activate to internal column command, cycles |
| cfg_tras | input | CNT_W | Activate to precharge, cycles |
| cfg_trp | input | CNT_W | Precharge to activate, cycles |
| cfg_trc | input | CNT_W | Activate to activate on the same bank, cycles |
| cfg_trrd | input | CNT_W | Activate to activate on different banks, cycles |
| cfg_al | input | AL_W | Additive latency, 0 to MAX_AL |
| bank_open | output | NBANK | One open flag per bank |
| open_row | output | NBANK*ROW_W | Open row of each bank, bank b at bits b*ROW_W upward |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Reason code while `viol` is high, else 0 |

## Verification
The assertions assume that the additive latency and the timing inputs stay constant while a posted column command is in flight. They also assume that reset is held for at least one clock edge before checking begins. The activate-to-open-bank property relies on knowing whether a posted issue falls in the same cycle, because that issue would win the code. The bench changes `cfg_al` only after idle stretches longer than the largest latency, so no posted command straddles a change. It drives exactly one pin pattern per cycle and lines up the one collision case on purpose, to exercise the priority order.

// File: rtl/act_timing_pkg.sv
package act_timing_pkg;

   typedef enum logic [2:0] {
      VC_NONE     = 3'd0,
      VC_ACT_OPEN = 3'd1,
      VC_TRC      = 3'd2,
      VC_TRP      = 3'd3,
      VC_TRRD     = 3'd4,
      VC_TRAS     = 3'd5,
      VC_TRCD     = 3'd6,
      VC_CLOSED   = 3'd7
   } viol_e;

   typedef enum logic [2:0] {
      BC_IDLE,
      BC_ACT,
      BC_PRE,
      BC_RD,
      BC_WR
   } bus_cmd_e;

endpackage

// File: rtl/act_cmd_decode.sv
module act_cmd_decode
   import act_timing_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   output bus_cmd_e cmd
);
   always_comb begin
      cmd = BC_IDLE;
      if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = BC_ACT;
            3'b010:  cmd = BC_PRE;
            3'b101:  cmd = BC_RD;
            3'b100:  cmd = BC_WR;
            default: cmd = BC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/act_down_ctr.sv
module act_down_ctr #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] span,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= (span == '0) ? '0 : span - W'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - W'(1);
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/act_bank_slot.sv
module act_bank_slot #(
   parameter int ROW_W = 14,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             do_act,
   input  logic             do_pre,
   input  logic [ROW_W-1:0] row_in,
   input  logic [CNT_W-1:0] t_rcd,
   input  logic [CNT_W-1:0] t_ras,
   input  logic [CNT_W-1:0] t_rc,
   input  logic [CNT_W-1:0] t_rp,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q,
   output logic             rcd_ok,
   output logic             ras_ok,
   output logic             rc_ok,
   output logic             rp_ok
);
   always_ff @(posedge clk) begin
      if (rst) begin
         is_open <= 1'b0;
         row_q   <= '0;
      end else if (do_act) begin
         is_open <= 1'b1;
         row_q   <= row_in;
      end else if (do_pre) begin
         is_open <= 1'b0;
      end
   end

   act_down_ctr #(.W(CNT_W)) u_rcd (.clk(clk), .rst(rst), .load(do_act), .span(t_rcd), .expired(rcd_ok));
   act_down_ctr #(.W(CNT_W)) u_ras (.clk(clk), .rst(rst), .load(do_act), .span(t_ras), .expired(ras_ok));
   act_down_ctr #(.W(CNT_W)) u_rc  (.clk(clk), .rst(rst), .load(do_act), .span(t_rc),  .expired(rc_ok));
   act_down_ctr #(.W(CNT_W)) u_rp  (.clk(clk), .rst(rst), .load(do_pre), .span(t_rp),  .expired(rp_ok));
endmodule

// File: rtl/act_post_line.sv
module act_post_line #(
   parameter int BANK_W = 2,
   parameter int MAX_AL = 5,
   parameter int AL_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [BANK_W-1:0] push_bank,
   input  logic [AL_W-1:0]   al,
   output logic              iss_v,
   output logic [BANK_W-1:0] iss_bank
);
   generate
      if (MAX_AL == 0) begin : g_direct
         assign iss_v    = push;
         assign iss_bank = push_bank;
      end else begin : g_line
         logic [AL_W-1:0]   al_eff;
         logic              v_q [MAX_AL];
         logic [BANK_W-1:0] b_q [MAX_AL];

         assign al_eff = (al > AL_W'(MAX_AL)) ? AL_W'(MAX_AL) : al;

         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < MAX_AL; i++) begin
                  v_q[i] <= 1'b0;
                  b_q[i] <= '0;
               end
            end else begin
               for (int i = 0; i < MAX_AL; i++) begin
                  if (i == MAX_AL - 1) begin
                     v_q[i] <= 1'b0;
                  end else begin
                     v_q[i] <= v_q[i+1];
                     b_q[i] <= b_q[i+1];
                  end
                  if (push && al_eff != '0 && (int'(al_eff) - 1) == i) begin
                     v_q[i] <= 1'b1;
                     b_q[i] <= push_bank;
                  end
               end
            end
         end

         assign iss_v    = v_q[0] | (push && al_eff == '0);
         assign iss_bank = v_q[0] ? b_q[0] : push_bank;
      end
   endgenerate
endmodule

// File: rtl/act_timing_guard.sv
module act_timing_guard
   import act_timing_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 14,
   parameter int CNT_W  = 6,
   parameter int MAX_AL = 5,
   parameter int AL_W   = 3,
   localparam int NBANK = 1 << BANK_W
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BANK_W-1:0]      bank_sel,
   input  logic [ROW_W-1:0]       row_addr,
   input  logic [CNT_W-1:0]       cfg_trcd,
   input  logic [CNT_W-1:0]       cfg_tras,
   input  logic [CNT_W-1:0]       cfg_trp,
   input  logic [CNT_W-1:0]       cfg_trc,
   input  logic [CNT_W-1:0]       cfg_trrd,
   input  logic [AL_W-1:0]        cfg_al,
   output logic [NBANK-1:0]       bank_open,
   output logic [NBANK*ROW_W-1:0] open_row,
   output logic                   viol,
   output logic [2:0]             viol_code
);
   generate
      if (ROW_W < 13 || ROW_W > 14) begin : g_bad_row
         $error("act_timing_guard: ROW_W must be 13 or 14");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("act_timing_guard: BANK_W must be at least 1");
      end
      if (MAX_AL < 0 || MAX_AL > (1 << AL_W) - 1) begin : g_bad_al
         $error("act_timing_guard: MAX_AL must fit in AL_W bits");
      end
   endgenerate

   bus_cmd_e          cmd;
   logic              is_rw;
   logic              iss_v;
   logic [BANK_W-1:0] iss_bank;
   logic              act_ok;
   logic              rrd_ok;
   logic [BANK_W-1:0] last_bank_q;
   logic [NBANK-1:0]  rcd_ok, ras_ok, rc_ok, rp_ok;
   viol_e             iss_code, bus_code, code_n;
   logic              viol_q;
   logic [2:0]        code_q;

   act_cmd_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   assign is_rw = (cmd == BC_RD) || (cmd == BC_WR);

   act_post_line #(.BANK_W(BANK_W), .MAX_AL(MAX_AL), .AL_W(AL_W)) u_post (
      .clk(clk), .rst(rst), .push(is_rw), .push_bank(bank_sel), .al(cfg_al),
      .iss_v(iss_v), .iss_bank(iss_bank)
   );

   assign act_ok = (cmd == BC_ACT) && !bank_open[bank_sel];

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      act_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
         .clk(clk), .rst(rst),
         .do_act(act_ok && bank_sel == BANK_W'(g)),
         .do_pre(cmd == BC_PRE && bank_sel == BANK_W'(g) && bank_open[g]),
         .row_in(row_addr),
         .t_rcd(cfg_trcd), .t_ras(cfg_tras), .t_rc(cfg_trc), .t_rp(cfg_trp),
         .is_open(bank_open[g]),
         .row_q(open_row[g*ROW_W +: ROW_W]),
         .rcd_ok(rcd_ok[g]), .ras_ok(ras_ok[g]), .rc_ok(rc_ok[g]), .rp_ok(rp_ok[g])
      );
   end

   act_down_ctr #(.W(CNT_W)) u_rrd (
      .clk(clk), .rst(rst), .load(act_ok), .span(cfg_trrd), .expired(rrd_ok)
   );

   always_ff @(posedge clk) begin
      if (rst)
         last_bank_q <= '0;
      else if (act_ok)
         last_bank_q <= bank_sel;
   end

   always_comb begin
      iss_code = VC_NONE;
      if (iss_v) begin
         if (!bank_open[iss_bank])
            iss_code = VC_CLOSED;
         else if (!rcd_ok[iss_bank])
            iss_code = VC_TRCD;
      end
   end

   always_comb begin
      bus_code = VC_NONE;
      case (cmd)
         BC_ACT: begin
            if (bank_open[bank_sel])
               bus_code = VC_ACT_OPEN;
            else if (!rc_ok[bank_sel])
               bus_code = VC_TRC;
            else if (!rp_ok[bank_sel])
               bus_code = VC_TRP;
            else if (!rrd_ok && last_bank_q != bank_sel)
               bus_code = VC_TRRD;
         end
         BC_PRE: begin
            if (bank_open[bank_sel] && !ras_ok[bank_sel])
               bus_code = VC_TRAS;
         end
         default: bus_code = VC_NONE;
      endcase
   end

   assign code_n = (iss_code != VC_NONE) ? iss_code : bus_code;

   always_ff @(posedge clk) begin
      if (rst) begin
         viol_q <= 1'b0;
         code_q <= 3'd0;
      end else begin
         viol_q <= (code_n != VC_NONE);
         code_q <= code_n;
      end
   end

   assign viol      = viol_q;
   assign viol_code = code_q;
endmodule

// File: rtl/act_timing_guard_chk.sv
module act_timing_guard_chk #(
   parameter int BANK_W = 2,
   parameter int NBANK  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BANK_W-1:0] bank_sel,
   input logic [NBANK-1:0]  bank_open,
   input logic              viol,
   input logic [2:0]        viol_code,
   input logic              iss_v
);
   logic act_pins, pre_pins;
   assign act_pins = !cs_n && !ras_n &&  cas_n &&  we_n;
   assign pre_pins = !cs_n && !ras_n &&  cas_n && !we_n;

   p_act_opens_r1: assert property (@(posedge clk) disable iff (rst)
      act_pins && !bank_open[bank_sel] |=> bank_open[$past(bank_sel)]);

   p_pre_closes_r2: assert property (@(posedge clk) disable iff (rst)
      pre_pins |=> !bank_open[$past(bank_sel)]);

   p_act_open_flag_r3: assert property (@(posedge clk) disable iff (rst)
      act_pins && bank_open[bank_sel] && !iss_v |=> viol && viol_code == 3'd1);

   p_code_pairs_r10: assert property (@(posedge clk) disable iff (rst)
      viol == (viol_code != 3'd0));

   p_idle_keeps_r11: assert property (@(posedge clk) disable iff (rst)
      cs_n |=> bank_open == $past(bank_open));

   p_one_opens_r1: assert property (@(posedge clk) disable iff (rst)
      $countones(bank_open & ~$past(bank_open)) <= 1);
endmodule

bind act_timing_guard act_timing_guard_chk #(.BANK_W(BANK_W), .NBANK(NBANK)) u_chk (
   .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
   .bank_sel(bank_sel), .bank_open(bank_open), .viol(viol), .viol_code(viol_code),
   .iss_v(iss_v)
);

// File: tb/act_timing_guard_test.sv
module act_timing_guard_test;
   localparam int BANK_W = 2;
   localparam int ROW_W  = 14;
   localparam int CNT_W  = 6;
   localparam int AL_W   = 3;
   localparam int NBANK  = 4;

   localparam logic [3:0] P_ACT = 4'b0011;
   localparam logic [3:0] P_PRE = 4'b0010;
   localparam logic [3:0] P_RD  = 4'b0101;
   localparam logic [3:0] P_WR  = 4'b0100;
   localparam logic [3:0] P_NOP = 4'b0111;
   localparam logic [3:0] P_DES = 4'b1000;
   localparam logic [3:0] P_REF = 4'b0001;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [BANK_W-1:0] bank_sel = '0;
   logic [ROW_W-1:0]  row_addr = '0;
   logic [CNT_W-1:0]  cfg_trcd = 6'd3, cfg_tras = 6'd6, cfg_trp = 6'd3;
   logic [CNT_W-1:0]  cfg_trc = 6'd9, cfg_trrd = 6'd2;
   logic [AL_W-1:0]   cfg_al = 3'd2;
   logic [NBANK-1:0]       bank_open;
   logic [NBANK*ROW_W-1:0] open_row;
   logic                   viol;
   logic [2:0]             viol_code;

   act_timing_guard uut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .bank_sel(bank_sel), .row_addr(row_addr),
      .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
      .cfg_trc(cfg_trc), .cfg_trrd(cfg_trrd), .cfg_al(cfg_al),
      .bank_open(bank_open), .open_row(open_row), .viol(viol), .viol_code(viol_code)
   );

   always #10 clk = ~clk;

   typedef struct {
      int         due;
      logic [2:0] code;
      string      tag;
   } exp_t;

   exp_t exq[$];
   int total = 0;
   int bad = 0;
   int cyc = 0;
   int last_c = 0;
   int viol_seen = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic expect_at(input int due, input logic [2:0] code, input string tag);
      exp_t e;
      e.due = due; e.code = code; e.tag = tag;
      exq.push_back(e);
   endtask

   task automatic drv(input logic [3:0] pins, input int bank, input int row);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = pins;
      bank_sel = BANK_W'(bank);
      row_addr = ROW_W'(row);
      last_c = cyc;
      @(posedge clk);
      #1;
      {cs_n, ras_n, cas_n, we_n} = P_NOP;
   endtask

   task automatic nop(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int row_of(input int b);
      return int'(open_row[b*ROW_W +: ROW_W]);
   endfunction

   // monitor: compares every cycle's violation output with the scoreboard
   always begin
      @(posedge clk);
      #5;
      cyc++;
      if (!rst) begin
         logic [2:0] exp_code;
         string      tag;
         exp_code = 3'd0;
         tag = "R10 idle";
         for (int i = 0; i < exq.size(); i++) begin
            if (exq[i].due == cyc) begin
               exp_code = exq[i].code;
               tag = exq[i].tag;
               exq.delete(i);
               break;
            end
         end
         if (viol) viol_seen++;
         chk(viol == (exp_code != 3'd0) && viol_code == exp_code, tag,
             int'({viol, viol_code}), int'({exp_code != 3'd0, exp_code}));
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int c0;
      logic [NBANK-1:0] keep;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R12: reset state
      chk(bank_open == '0, "R12 banks closed", int'(bank_open), 0);
      chk(viol == 1'b0 && viol_code == 3'd0, "R12 no violation", int'(viol_code), 0);
      nop(1);

      // R1, R13, R12: activate right after reset, read posted one cycle later
      drv(P_ACT, 0, 14'h1A5);
      drv(P_RD, 0, 0);
      nop(8);
      chk(bank_open[0], "R1 bank0 open", int'(bank_open), 1);
      chk(row_of(0) == 14'h1A5, "R1 bank0 row", row_of(0), 14'h1A5);
      chk(viol_seen == 0, "R13 posted read legal", viol_seen, 0);

      // R6: activates on different banks one cycle apart
      drv(P_ACT, 1, 14'h0011);
      drv(P_ACT, 2, 14'h0022);
      expect_at(last_c + 1, 3'd4, "R6");
      nop(10);
      chk(bank_open[2], "R6 activate still taken", int'(bank_open), 4'b0111);

      // R3: activate to open bank ignored
      drv(P_ACT, 1, 14'h3333);
      expect_at(last_c + 1, 3'd1, "R3");
      nop(3);
      chk(row_of(1) == 14'h0011, "R3 row kept", row_of(1), 14'h0011);

      // R5, R7, R4
      drv(P_PRE, 1, 0);
      drv(P_ACT, 1, 14'h0044);
      expect_at(last_c + 1, 3'd3, "R5");
      drv(P_PRE, 1, 0);
      expect_at(last_c + 1, 3'd5, "R7");
      nop(3);
      chk(!bank_open[1], "R7 bank still closes", int'(bank_open[1]), 0);
      drv(P_ACT, 1, 14'h0055);
      expect_at(last_c + 1, 3'd2, "R4");
      nop(12);
      chk(row_of(1) == 14'h0055, "R4 activate still taken", row_of(1), 14'h0055);

      // R8: posted read with AL=1 issued too early
      cfg_al = 3'd1;
      drv(P_ACT, 3, 14'h0066);
      drv(P_RD, 3, 0);
      expect_at(last_c + 2, 3'd6, "R8 al1");
      nop(6);
      // R8: write with AL=0 checked at bus time
      cfg_al = 3'd0;
      drv(P_PRE, 2, 0);
      nop(5);
      drv(P_ACT, 2, 14'h0077);
      drv(P_WR, 2, 0);
      expect_at(last_c + 1, 3'd6, "R8 al0");
      nop(6);
      cfg_al = 3'd2;
      nop(6);

      // R2, R9: precharge then posted read to the closed bank
      drv(P_PRE, 0, 0);
      nop(3);
      chk(!bank_open[0], "R2 precharge closes", int'(bank_open[0]), 0);
      drv(P_RD, 0, 0);
      expect_at(last_c + 3, 3'd7, "R9");
      nop(6);

      // R10: posted issue fault and bus fault in the same cycle
      drv(P_RD, 0, 0);
      c0 = last_c;
      nop(1);
      drv(P_ACT, 3, 14'h0099);
      expect_at(c0 + 3, 3'd7, "R10 priority");
      nop(6);
      chk(row_of(3) == 14'h0066, "R10 ignored activate", row_of(3), 14'h0066);

      // R11, R2: idle patterns and precharge of a closed bank
      keep = bank_open;
      drv(P_DES, 0, 14'h0AAA);
      drv(P_REF, 1, 14'h0BBB);
      drv(P_PRE, 0, 0);
      nop(4);
      chk(bank_open == keep, "R11 state unchanged", int'(bank_open), int'(keep));
      chk(row_of(1) == 14'h0055, "R11 row unchanged", row_of(1), 14'h0055);

      nop(4);
      chk(exq.size() == 0, "R10 all expected pulses seen", exq.size(), 0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule